// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store placed between a direct-mapped primary cache and the next lower level of the memory hierarchy. It keeps lines that the primary cache has just thrown out. When the primary cache misses, the same block address is looked up here. On a hit, the line comes back at once and no lower-level access is needed. Conflict misses between blocks that share a set are therefore served from the buffer, while the primary cache keeps its short hit path.

Every entry holds one complete line. With each line it keeps the full block address (primary tag and set index together), because an entry is not tied to any set. It also keeps a dirty flag. Each entry has its own address comparator, so all entries are searched together. The primary cache offers lines in two ways:
- A plain eviction. The line is inserted.
- A lookup. The lookup may carry the line that currently occupies the target set. On a hit that line is swapped into the entry that just hit. On a miss the lookup is forwarded to lower memory and the carried line is inserted.

If a dirty line is pushed out of a full buffer, the block asks the lower level to write it back.

The controller is a five-state machine:
- **IDLE**: `ready` is high. A lookup goes to SEARCH. Otherwise an eviction goes to INSERT.
- **SEARCH**: the comparators run. A match goes to HIT, no match goes to MISS.
- **HIT**: the response is given. The entry is overwritten with the carried line, or freed if no line was carried. The state returns to IDLE.
- **MISS**: the miss response and the lower-level request are given. The state goes to INSERT if a line was carried, else to IDLE.
- **INSERT**: the line is written. A write-back is raised if needed. The state returns to IDLE.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty, `ready` is 1 and `rsp_valid`, `mem_req_valid` and `wb_valid` are 0, so a first lookup misses.
- R2: A lookup accepted at a clock edge (lookup valid while `ready` is 1) that matches a stored block address gives, after the second following edge, one cycle of `rsp_valid`=1 and `rsp_hit`=1, with the stored line on `rsp_data` and its dirty flag on `rsp_dirty`; `mem_req_valid` stays 0.
- R3: A lookup that matches no entry gives, after the second following edge, one cycle with `rsp_valid`=1, `rsp_hit`=0, `mem_req_valid`=1 and `mem_req_addr` equal to the looked-up block address.
- R4: On a hit, if the lookup carried a line (`swap_valid`=1), that line with its address and dirty flag replaces the matching entry; otherwise the matching entry becomes empty.
- R5: A line to insert goes into the empty entry with the lowest index while any entry is empty; the replacement pointer does not move.
- R6: When all entries are full, the insertion replaces the entry at a replacement pointer. The pointer starts at 0 after reset and steps by one, wrapping from NUM_ENT-1 to 0, after each such replacement.
- R7: Replacing a full entry whose dirty flag is 1 raises `wb_valid` for exactly one cycle with that entry's address and line on `wb_addr` and `wb_data`. Replacing a clean entry, or filling an empty one, raises nothing.
- R8: On a miss with a carried line, that line is inserted by the rules of R5 to R7, with the write-back visible after the third edge following acceptance. A plain eviction is inserted the same way, with any write-back visible after the first edge.
- R9: When a lookup and an eviction are offered in the same cycle, only the lookup is taken and the eviction has no effect. No request is accepted while `ready` is 0.
- R10: All entries are compared in the same cycle. The response latency of R2 and R3 does not depend on which entry holds the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | Primary cache discards a line |
| evict_addr | input | ADDR_W | Block address of the discarded line |
| evict_data | input | LINE_W | Discarded line |
| evict_dirty | input | 1 | Discarded line is modified |
| lk_valid | input | 1 | Lookup request after a primary miss |
| lk_addr | input | ADDR_W | Block address looked up |
| swap_valid | input | 1 | Lookup carries the line currently in the target set |
| swap_addr | input | ADDR_W | Block address of the carried line |
| swap_data | input | LINE_W | Carried line |
| swap_dirty | input | 1 | Carried line is modified |
| ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | LINE_W | Line returned on a hit, zero otherwise |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| mem_req_valid | output | 1 | Forwarded fetch to the lower level |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| wb_valid | output | 1 | Write-back of a pushed-out dirty line |
| wb_addr | output | ADDR_W | Block address written back |
| wb_data | output | LINE_W | Line written back |

## Verification
Directed sequences first fill the buffer and read every entry back, so a wrong entry selection or wrong data shows up. Lookups without a carried line then free entries, which exposes whether new lines take the lowest free slot or follow the pointer. Further insertions into the full buffer walk the pointer through a wrap, with clean and dirty victims mixed, to separate correct write-back requests from missing or spurious ones. A request offering both a lookup and an eviction tests the priority rule. A seeded random mix of evictions and lookups over a small address range, with and without carried lines, follows. It is scored against a reference model of the entries and pointer, which exposes any drift in swap, fill or replacement order together with response latency.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_HIT,
        ST_MISS,
        ST_INSERT
    } vc_state_e;
endpackage

// File: rtl/vc_entry_array.sv
module vc_entry_array #(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 12,
    parameter int LINE_W  = 64,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cmp_addr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [LINE_W-1:0]  wr_data,
    input  logic               wr_dirty,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [NUM_ENT-1:0] valid_vec,
    output logic [NUM_ENT-1:0] match_vec,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [LINE_W-1:0]  rd_data,
    output logic               rd_dirty
);
    logic [ADDR_W-1:0] ent_addr  [NUM_ENT];
    logic [LINE_W-1:0] ent_data  [NUM_ENT];
    logic              ent_dirty [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g]  <= 1'b0;
                ent_addr[g]   <= '0;
                ent_data[g]   <= '0;
                ent_dirty[g]  <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_vec[g]  <= 1'b1;
                ent_addr[g]   <= wr_addr;
                ent_data[g]   <= wr_data;
                ent_dirty[g]  <= wr_dirty;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                valid_vec[g]  <= 1'b0;
                ent_dirty[g]  <= 1'b0;
            end
        end

        // one comparator per entry, all evaluated in the same cycle
        assign match_vec[g] = valid_vec[g] && (ent_addr[g] == cmp_addr);
    end

    assign rd_addr  = ent_addr[rd_idx];
    assign rd_data  = ent_data[rd_idx];
    assign rd_dirty = ent_dirty[rd_idx];

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R10

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_idx)]); // R5
endmodule

// File: rtl/vc_repl.sv
module vc_repl #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   ins_idx,
    output logic               full
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign full    = &valid_vec;
    assign ins_idx = full ? ptr : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)          ptr <= '0;
        else if (advance)    ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
    end

    AST_FREE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !valid_vec[ins_idx]); // R5

    AST_PTR_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !full |=> $stable(ptr)); // R6
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 12,
    parameter int LINE_W  = 64,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evict_valid,
    input  logic [ADDR_W-1:0]  evict_addr,
    input  logic [LINE_W-1:0]  evict_data,
    input  logic               evict_dirty,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               swap_valid,
    input  logic [ADDR_W-1:0]  swap_addr,
    input  logic [LINE_W-1:0]  swap_data,
    input  logic               swap_dirty,
    input  logic [NUM_ENT-1:0] match_vec,
    input  logic               full,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [LINE_W-1:0]  rd_data,
    input  logic               rd_dirty,
    output logic [ADDR_W-1:0]  cmp_addr,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [LINE_W-1:0]  wr_data,
    output logic               wr_dirty,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               advance,
    output logic               ready,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [LINE_W-1:0]  rsp_data,
    output logic               rsp_dirty,
    output logic               mem_req_valid,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic               wb_valid,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [LINE_W-1:0]  wb_data
);
    vc_state_e state, state_nx;

    logic [ADDR_W-1:0] req_addr;
    logic              line_ok;
    logic [ADDR_W-1:0] line_addr;
    logic [LINE_W-1:0] line_data;
    logic              line_dirty;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  hit_enc;

    always_comb begin
        hit_enc = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (match_vec[i]) hit_enc = IDX_W'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (lk_valid)          state_nx = ST_SEARCH;
                else if (evict_valid)  state_nx = ST_INSERT;
            end
            ST_SEARCH: state_nx = (|match_vec) ? ST_HIT : ST_MISS;
            ST_HIT:    state_nx = ST_IDLE;
            ST_MISS:   state_nx = line_ok ? ST_INSERT : ST_IDLE;
            ST_INSERT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr   <= '0;
            line_ok    <= 1'b0;
            line_addr  <= '0;
            line_data  <= '0;
            line_dirty <= 1'b0;
            hit_idx    <= '0;
        end else begin
            if (state == ST_IDLE && lk_valid) begin
                req_addr   <= lk_addr;
                line_ok    <= swap_valid;
                line_addr  <= swap_addr;
                line_data  <= swap_data;
                line_dirty <= swap_dirty;
            end else if (state == ST_IDLE && evict_valid) begin
                line_ok    <= 1'b1;
                line_addr  <= evict_addr;
                line_data  <= evict_data;
                line_dirty <= evict_dirty;
            end
            if (state == ST_SEARCH) hit_idx <= hit_enc;
        end
    end

    // outputs
    always_comb begin
        ready         = 1'b0;
        rsp_valid     = 1'b0;
        rsp_hit       = 1'b0;
        rsp_data      = '0;
        rsp_dirty     = 1'b0;
        mem_req_valid = 1'b0;
        wb_valid      = 1'b0;
        wr_en         = 1'b0;
        clr_en        = 1'b0;
        advance       = 1'b0;
        wr_idx        = ins_idx;
        rd_idx        = hit_idx;
        unique case (state)
            ST_IDLE: ready = 1'b1;
            ST_SEARCH: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_data  = rd_data;
                rsp_dirty = rd_dirty;
                wr_idx    = hit_idx;
                wr_en     = line_ok;
                clr_en    = !line_ok;
            end
            ST_MISS: begin
                rsp_valid     = 1'b1;
                mem_req_valid = 1'b1;
            end
            ST_INSERT: begin
                rd_idx   = ins_idx;
                wr_en    = 1'b1;
                advance  = full;
                wb_valid = full && rd_dirty;
            end
            default: ;
        endcase
    end

    assign cmp_addr     = req_addr;
    assign clr_idx      = hit_idx;
    assign wr_addr      = line_addr;
    assign wr_data      = line_data;
    assign wr_dirty     = line_dirty;
    assign mem_req_addr = req_addr;
    assign wb_addr      = rd_addr;
    assign wb_data      = rd_data;

    AST_HIT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && |match_vec) |=> (rsp_hit && !mem_req_valid)); // R2

    AST_MISS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && match_vec == '0) |=> (mem_req_valid && mem_req_addr == $past(cmp_addr))); // R3

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2

    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (!wb_valid && ready)); // R7

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && state != ST_MISS) |=> !($past(state) == ST_SEARCH && ready)); // R9
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 12,
    parameter int LINE_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              evict_dirty,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              swap_valid,
    input  logic [ADDR_W-1:0] swap_addr,
    input  logic [LINE_W-1:0] swap_data,
    input  logic              swap_dirty,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic [NUM_ENT-1:0] valid_vec, match_vec;
    logic [ADDR_W-1:0]  cmp_addr, wr_addr, rd_addr;
    logic [LINE_W-1:0]  wr_data, rd_data;
    logic               wr_en, wr_dirty, clr_en, rd_dirty, advance, full;
    logic [IDX_W-1:0]   wr_idx, clr_idx, rd_idx, ins_idx;

    vc_entry_array #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .cmp_addr(cmp_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data), .wr_dirty(wr_dirty),
        .clr_en(clr_en), .clr_idx(clr_idx), .rd_idx(rd_idx),
        .valid_vec(valid_vec), .match_vec(match_vec),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_dirty(rd_dirty)
    );

    vc_repl #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_repl (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .advance(advance),
        .ins_idx(ins_idx), .full(full)
    );

    vc_ctrl #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data), .evict_dirty(evict_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .swap_valid(swap_valid), .swap_addr(swap_addr), .swap_data(swap_data), .swap_dirty(swap_dirty),
        .match_vec(match_vec), .full(full), .ins_idx(ins_idx),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_dirty(rd_dirty),
        .cmp_addr(cmp_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_dirty(wr_dirty), .clr_en(clr_en), .clr_idx(clr_idx),
        .rd_idx(rd_idx), .advance(advance),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_dirty(rsp_dirty), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );
endmodule

// File: tb/sim_victim_buffer.sv
module sim_victim_buffer;
    localparam int NE = 4;
    localparam int AW = 12;
    localparam int LW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evict_valid = 0, evict_dirty = 0, lk_valid = 0, swap_valid = 0, swap_dirty = 0;
    logic [AW-1:0] evict_addr = '0, lk_addr = '0, swap_addr = '0;
    logic [LW-1:0] evict_data = '0, swap_data = '0;
    logic ready, rsp_valid, rsp_hit, rsp_dirty, mem_req_valid, wb_valid;
    logic [LW-1:0] rsp_data, wb_data;
    logic [AW-1:0] mem_req_addr, wb_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit          m_v  [NE];
    logic [AW-1:0] m_a [NE];
    logic [LW-1:0] m_d [NE];
    bit          m_dt [NE];
    int          m_ptr;

    always #2.5 clk = ~clk;

    victim_buffer #(.NUM_ENT(NE), .ADDR_W(AW), .LINE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data), .evict_dirty(evict_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .swap_valid(swap_valid), .swap_addr(swap_addr), .swap_data(swap_data), .swap_dirty(swap_dirty),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_a[i] == a) return i;
        return -1;
    endfunction

    // returns 1 if a write-back is expected, with its address and data
    function automatic bit m_insert(input logic [AW-1:0] a, input logic [LW-1:0] d, input bit dt,
                                    output logic [AW-1:0] wa, output logic [LW-1:0] wd);
        int slot = -1;
        bit wbx = 0;
        wa = '0; wd = '0;
        for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
            slot = m_ptr;
            wbx = m_dt[slot];
            wa = m_a[slot]; wd = m_d[slot];
            m_ptr = (m_ptr + 1) % NE;
        end
        m_v[slot] = 1; m_a[slot] = a; m_d[slot] = d; m_dt[slot] = dt;
        return wbx;
    endfunction

    // observations of one operation
    int o_rsp_n, o_req_n, o_wb_n, o_rsp_cnt, o_wb_cnt;
    bit o_hit, o_dirty;
    logic [LW-1:0] o_data, o_wbd;
    logic [AW-1:0] o_req_a, o_wba;

    task automatic run_op();
        int n = 0;
        o_rsp_n = -1; o_req_n = -1; o_wb_n = -1; o_rsp_cnt = 0; o_wb_cnt = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                lk_valid = 0; evict_valid = 0; swap_valid = 0;
            end
            if (rsp_valid) begin
                o_rsp_cnt++; o_rsp_n = n; o_hit = rsp_hit; o_data = rsp_data; o_dirty = rsp_dirty;
            end
            if (mem_req_valid) begin o_req_n = n; o_req_a = mem_req_addr; end
            if (wb_valid) begin o_wb_cnt++; o_wb_n = n; o_wba = wb_addr; o_wbd = wb_data; end
            if (ready || n > 10) break;
        end
    endtask

    task automatic check_wb(input string tag, input bit exp_wb, input int exp_n,
                            input logic [AW-1:0] ea, input logic [LW-1:0] ed);
        if (exp_wb) begin
            check(o_wb_cnt == 1 && o_wb_n == exp_n, "R7", {tag, " writeback pulse/latency"}, LW'(o_wb_n), LW'(exp_n));
            check(o_wba == ea && o_wbd == ed, "R7", {tag, " writeback content"}, {o_wbd[LW-AW-1:0], o_wba}, {ed[LW-AW-1:0], ea});
        end else begin
            check(o_wb_cnt == 0, "R7", {tag, " no writeback"}, LW'(o_wb_cnt), 0);
        end
    endtask

    task automatic do_evict(input string tag, input logic [AW-1:0] a, input logic [LW-1:0] d, input bit dt);
        logic [AW-1:0] wa; logic [LW-1:0] wd; bit ew;
        @(negedge clk);
        while (!ready) @(negedge clk);
        evict_valid = 1; evict_addr = a; evict_data = d; evict_dirty = dt;
        ew = m_insert(a, d, dt, wa, wd);
        run_op();
        check(o_rsp_cnt == 0, "R8", {tag, " eviction gives no response"}, LW'(o_rsp_cnt), 0);
        check_wb({tag, " R8"}, ew, 1, wa, wd);
    endtask

    task automatic do_lookup(input string tag, input logic [AW-1:0] a, input bit sv,
                             input logic [AW-1:0] sa, input logic [LW-1:0] sd, input bit sdt,
                             input bit also_evict);
        int idx;
        logic [AW-1:0] wa; logic [LW-1:0] wd; bit ew = 0;
        logic [LW-1:0] exp_d; bit exp_dt;
        @(negedge clk);
        while (!ready) @(negedge clk);
        lk_valid = 1; lk_addr = a; swap_valid = sv; swap_addr = sa; swap_data = sd; swap_dirty = sdt;
        if (also_evict) begin
            evict_valid = 1; evict_addr = sa ^ 12'h800; evict_data = ~sd; evict_dirty = 1;
        end
        idx = m_find(a);
        exp_d = '0; exp_dt = 0;
        if (idx >= 0) begin
            exp_d = m_d[idx]; exp_dt = m_dt[idx];
            if (sv) begin m_a[idx] = sa; m_d[idx] = sd; m_dt[idx] = sdt; end
            else begin m_v[idx] = 0; m_dt[idx] = 0; end
        end else if (sv) begin
            ew = m_insert(sa, sd, sdt, wa, wd);
        end
        run_op();
        check(o_rsp_cnt == 1 && o_rsp_n == 2, "R10", {tag, " response latency"}, LW'(o_rsp_n), 2);
        if (idx >= 0) begin
            check(o_hit == 1, "R2", {tag, " hit flag"}, LW'(o_hit), 1);
            check(o_data == exp_d && o_dirty == exp_dt, tag, "hit line and dirty", o_data, exp_d);
            check(o_req_n == -1, "R2", {tag, " no lower request on hit"}, LW'(o_req_n), LW'(-1));
        end else begin
            check(o_hit == 0, "R3", {tag, " miss flag"}, LW'(o_hit), 0);
            check(o_req_n == 2 && o_req_a == a, "R3", {tag, " forwarded request"}, LW'(o_req_a), LW'(a));
        end
        check_wb({tag, " R8"}, ew, 3, wa, wd);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_a[i] = '0; m_d[i] = '0; m_dt[i] = 0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(ready == 1, "R1", "ready after reset", LW'(ready), 1);
        check(!rsp_valid && !mem_req_valid && !wb_valid, "R1", "outputs quiet after reset",
              LW'({rsp_valid, mem_req_valid, wb_valid}), 0);
        do_lookup("R1", 12'h010, 0, '0, '0, 0, 0);

        // fill, then read every entry (R5, R2)
        for (int i = 0; i < NE; i++) do_evict("R5", AW'(12'h100 + i), 64'hA000_0000_0000_0000 | LW'(i), (i % 2) == 0);
        for (int i = 0; i < NE; i++) do_lookup("R2", AW'(12'h100 + i), 1, AW'(12'h100 + i),
                                               64'hA000_0000_0000_0000 | LW'(i), (i % 2) == 0, 0);
        // full: pointer replacement with dirty and clean victims (R6, R7)
        do_evict("R6", 12'h200, 64'h1111, 0);
        do_evict("R6", 12'h201, 64'h2222, 1);
        do_lookup("R6", 12'h100, 0, '0, '0, 0, 0);
        do_lookup("R6", 12'h201, 0, '0, '0, 0, 0);
        // freed slots take lowest index first (R4, R5)
        do_lookup("R4", 12'h102, 0, '0, '0, 0, 0);
        do_evict("R5", 12'h300, 64'h3333, 1);
        do_evict("R5", 12'h301, 64'h4444, 0);
        do_evict("R6", 12'h302, 64'h5555, 1);
        do_evict("R6", 12'h303, 64'h6666, 0);
        do_evict("R6", 12'h304, 64'h7777, 1);
        do_lookup("R4", 12'h303, 1, 12'h0F0, 64'h8888, 1, 0);
        do_lookup("R4", 12'h0F0, 0, '0, '0, 0, 0);
        // miss carrying a line (R8)
        do_lookup("R8", 12'h777, 1, 12'h0E0, 64'h9999, 1, 0);
        do_lookup("R8", 12'h0E0, 0, '0, '0, 0, 0);
        // lookup and eviction together: eviction ignored (R9)
        do_lookup("R9", 12'h555, 0, 12'h0D0, 64'hABCD, 0, 1);
        do_lookup("R9", 12'h8D0, 0, '0, '0, 0, 0);

        // seeded random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a, sa;
            logic [LW-1:0] d;
            a = AW'($urandom_range(0, 15));
            d = {$urandom(), $urandom()};
            if ($urandom_range(0, 2) == 0) begin
                if (m_find(a) < 0) do_evict("R5", a, d, $urandom_range(0, 1) == 1);
            end else begin
                bit sv = $urandom_range(0, 1) == 1;
                sa = AW'($urandom_range(16, 31));
                if (m_find(sa) >= 0) sv = 0;
                do_lookup(sv ? "R4" : "R2", a, sv, sa, d, $urandom_range(0, 1) == 1, 0);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule